// File: doc/BRIEF.md
# AXI Write Bridge with Posted and Non-Posted Response Timing

This block is the write half of a host bridge that carries AXI writes onto a PCI Express style request port. It takes single-beat AXI writes (address and data offered together, with an ID and the four memory-type bits) and turns each into a simplified outbound request. That request is either an I/O-space write or a memory-space write. A simplified completion input reports the result of every request that expects one.

The address picks the space. An address inside the I/O window, from `IO_BASE` to `IO_LAST` inclusive, becomes an I/O write. Any other address becomes a memory write. Memory-type bit 0 (bufferable) picks when the AXI response is returned:

- A bufferable memory write goes into a small posting queue and is answered at once.
- A non-bufferable write, whether memory or I/O, is held in a single slot. The queue drains ahead of it, it is issued, and it is answered only when its completion returns.
- A bufferable write that targets the I/O window is refused with an error and no request.

Only one write is in flight at the response stage, so responses leave in acceptance order.

The controller has five states:

- `ST_IDLE` accepts a write.
- `ST_DRAIN` waits for the posting queue to empty.
- `ST_ISSUE` offers the held request.
- `ST_WAIT_CPL` waits for the completion.
- `ST_RESP` presents the response.

It has these transitions:

- IDLE to RESP for a posted or refused write.
- IDLE to DRAIN for a held write.
- DRAIN to ISSUE once the queue is empty.
- ISSUE to WAIT_CPL on the request handshake.
- WAIT_CPL to RESP on completion.
- RESP to IDLE on the response handshake.

Top module: `pcie_wr_bridge`

## Requirements
- R1: A write whose address lies in [IO_BASE, IO_LAST] (defaults 0x1000..0x1FFF, both ends inclusive) is sent with req_is_io=1. Any other address is sent with req_is_io=0.
- R2: An I/O-window write with awcache[0]=0 is sent with req_np=1. Its B response (bresp OKAY=2'b00) appears only after cpl_valid has been seen for it.
- R3: A memory write with awcache[0]=1 is queued and answered OKAY without waiting for the downstream request handshake. It is sent with req_np=0.
- R4: A memory write with awcache[0]=0 is sent with req_np=1. Its B response is held until its completion arrives.
- R5: An I/O-window write with awcache[0]=1 is answered SLVERR (2'b10) and produces no downstream request.
- R6: A completion with cpl_err=1 makes the held write answer SLVERR instead of OKAY.
- R7: At most one I/O request is outstanding. awready stays low from the acceptance of a held write until its response is taken, so a second I/O write is requested only after the first one's completion.
- R8: The posting queue holds QDEPTH (default 4) writes. awready is low while it is full and rises again once an entry leaves.
- R9: bid equals the awid of the answered write. Responses leave in acceptance order, and bid and bresp hold while bvalid waits for bready.
- R10: Queued posted writes are requested in acceptance order, and all of them go ahead of any later held write.
- R11: After reset, awready=1, bvalid=0 and req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write address |
| awid | input | ID_W | Transaction ID |
| awcache | input | 4 | Memory type; bit 0 = bufferable |
| wvalid | input | 1 | Write data valid (must accompany awvalid) |
| wready | output | 1 | Write data ready (equals awready) |
| wdata | input | DATA_W | Write data |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response ready |
| bid | output | ID_W | Response ID |
| bresp | output | 2 | Response code |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request ready |
| req_is_io | output | 1 | 1 = I/O write, 0 = memory write |
| req_np | output | 1 | 1 = completion expected |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| cpl_valid | input | 1 | Completion strobe for the outstanding held request |
| cpl_err | input | 1 | Completion carries an error status |

## Verification
The hardest case to reach is a held write arriving behind queued posted writes that have not yet gone downstream. The bench gets there by stalling req_ready. It accepts posted writes, which are answered early while nothing leaves, and only then offers a non-bufferable I/O write. When it releases the port, the request order must show the queue draining first. A slow completion responder keeps two back-to-back I/O writes apart, and a monitor flags any second I/O request seen before the first completion.

// File: rtl/pcie_wr_pkg.sv
package pcie_wr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_ISSUE,
        ST_WAIT_CPL,
        ST_RESP
    } brg_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/pwb_decode.sv
module pwb_decode #(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] IO_BASE = 32'h0000_1000,
    parameter logic [31:0] IO_LAST = 32'h0000_1FFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cache,
    output logic              io_hit,
    output logic              bufferable,
    output logic              refuse
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(IO_LAST);

    logic unused_cache;
    assign unused_cache = ^cache[3:1];

    always_comb begin
        io_hit     = (addr >= LO) && (addr <= HI);
        bufferable = cache[0];
        refuse     = io_hit && cache[0];
    end
endmodule

// File: rtl/pwb_post_fifo.sv
module pwb_post_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W:0]   CNT_MAX  = (PTR_W+1)'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;

    assign empty = (count == '0);
    assign full  = (count == CNT_MAX);
    assign dout  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CNT_MAX || pop));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/pcie_wr_bridge.sv
module pcie_wr_bridge
    import pcie_wr_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          DATA_W  = 32,
    parameter int          ID_W    = 4,
    parameter int          QDEPTH  = 4,
    parameter logic [31:0] IO_BASE = 32'h0000_1000,
    parameter logic [31:0] IO_LAST = 32'h0000_1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic [ID_W-1:0]   awid,
    input  logic [3:0]        awcache,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    output logic              bvalid,
    input  logic              bready,
    output logic [ID_W-1:0]   bid,
    output logic [1:0]        bresp,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_is_io,
    output logic              req_np,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              cpl_valid,
    input  logic              cpl_err
);
    localparam int ENT_W = ADDR_W + DATA_W;

    brg_state_e state, state_nx;

    logic              io_hit, bufferable, refuse;
    logic              accept, q_push, q_pop, q_empty, q_full;
    logic [ENT_W-1:0]  q_head;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    logic              h_io;
    logic [ID_W-1:0]   r_id;
    logic [1:0]        r_resp;

    pwb_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_LAST(IO_LAST)) u_dec (
        .addr(awaddr), .cache(awcache),
        .io_hit(io_hit), .bufferable(bufferable), .refuse(refuse)
    );

    pwb_post_fifo #(.WIDTH(ENT_W), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .din({awaddr, wdata}),
        .pop(q_pop), .dout(q_head),
        .empty(q_empty), .full(q_full)
    );

    assign accept = (state == ST_IDLE) && !q_full && awvalid && wvalid;
    assign q_push = accept && bufferable && !io_hit;
    assign q_pop  = (state != ST_ISSUE) && !q_empty && req_ready;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = bufferable ? ST_RESP : ST_DRAIN;
            ST_DRAIN:    if (q_empty) state_nx = ST_ISSUE;
            ST_ISSUE:    if (req_ready) state_nx = ST_WAIT_CPL;
            ST_WAIT_CPL: if (cpl_valid) state_nx = ST_RESP;
            ST_RESP:     if (bready) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register and held-write context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            h_addr <= '0;
            h_data <= '0;
            h_io   <= 1'b0;
            r_id   <= '0;
            r_resp <= RESP_OKAY;
        end else begin
            state <= state_nx;
            if (accept) begin
                h_addr <= awaddr;
                h_data <= wdata;
                h_io   <= io_hit;
                r_id   <= awid;
                r_resp <= refuse ? RESP_SLVERR : RESP_OKAY;
            end
            if (state == ST_WAIT_CPL && cpl_valid)
                r_resp <= cpl_err ? RESP_SLVERR : RESP_OKAY;
        end
    end

    // outputs
    always_comb begin
        awready = (state == ST_IDLE) && !q_full;
        wready  = awready;
        bvalid  = (state == ST_RESP);
        bid     = r_id;
        bresp   = r_resp;
        if (state == ST_ISSUE) begin
            req_valid = 1'b1;
            req_addr  = h_addr;
            req_data  = h_data;
            req_is_io = h_io;
            req_np    = 1'b1;
        end else begin
            req_valid = !q_empty;
            req_addr  = q_head[ENT_W-1:DATA_W];
            req_data  = q_head[DATA_W-1:0];
            req_is_io = 1'b0;
            req_np    = 1'b0;
        end
    end

    // checker state: an I/O request is in flight until a completion returns
    logic io_out;
    always_ff @(posedge clk) begin
        if (!rst_n)                                  io_out <= 1'b0;
        else if (req_valid && req_ready && req_is_io) io_out <= 1'b1;
        else if (cpl_valid)                          io_out <= 1'b0;
    end

    assert_single_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_out |-> !(req_valid && req_is_io));
    assert_stall_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_out |-> !awready);
    assert_b_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_np)));
    assert_no_req_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && refuse) |=> !(req_valid && req_np));
endmodule

// File: tb/pcie_wr_bridge_test.sv
module pcie_wr_bridge_test;
    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  id;
        logic [3:0]  cache;
        logic        exp_io;
        logic        exp_req;
        logic [1:0]  exp_resp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{addr:32'h0000_1004, id:4'd1, cache:4'h0, exp_io:1'b1, exp_req:1'b1, exp_resp:2'b00},
        '{addr:32'h8000_0000, id:4'd2, cache:4'h1, exp_io:1'b0, exp_req:1'b1, exp_resp:2'b00},
        '{addr:32'h8000_0010, id:4'd3, cache:4'h0, exp_io:1'b0, exp_req:1'b1, exp_resp:2'b00},
        '{addr:32'h0000_1008, id:4'd4, cache:4'h1, exp_io:1'b1, exp_req:1'b0, exp_resp:2'b10},
        '{addr:32'h0000_1FFF, id:4'd5, cache:4'h0, exp_io:1'b1, exp_req:1'b1, exp_resp:2'b00},
        '{addr:32'h0000_2000, id:4'd6, cache:4'h3, exp_io:1'b0, exp_req:1'b1, exp_resp:2'b00},
        '{addr:32'h0000_0FFC, id:4'd7, cache:4'h0, exp_io:1'b0, exp_req:1'b1, exp_resp:2'b00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1;
    logic [31:0] awaddr = '0, wdata = '0;
    logic [3:0]  awid = '0, awcache = '0;
    logic awready, wready, bvalid, req_valid, req_is_io, req_np;
    logic [3:0]  bid;
    logic [1:0]  bresp;
    logic [31:0] req_addr, req_data;
    logic req_ready = 1'b0, cpl_valid = 1'b0, cpl_err = 1'b0;

    always #5 clk = ~clk;

    pcie_wr_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awid(awid), .awcache(awcache),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_io(req_is_io), .req_np(req_np),
        .req_addr(req_addr), .req_data(req_data),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err)
    );

    int checks = 0, fails = 0, cycles = 0;
    logic auto_ready = 1'b1, err_mode = 1'b0, io_busy = 1'b0;
    int cpl_delay = 3, cpl_cnt = 0;
    int req_n = 0, b_n = 0, cpl_n = 0;
    logic [31:0] rq_addr [64];
    logic        rq_io [64];
    logic        rq_np [64];
    logic [3:0]  b_id [64];
    logic [1:0]  b_rs [64];

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // downstream responder and logger, acting at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        if (cpl_valid) cpl_valid = 1'b0;
        if (cpl_cnt > 0) begin
            cpl_cnt--;
            if (cpl_cnt == 0) begin
                cpl_valid = 1'b1; cpl_err = err_mode; io_busy = 1'b0; cpl_n++;
            end
        end
        req_ready = auto_ready;
        if (rst_n && req_valid && req_ready) begin
            if (req_is_io) begin
                check(!io_busy, "R7 second I/O request before completion", 32'(io_busy), 32'd0);
                io_busy = 1'b1;
            end
            rq_addr[req_n] = req_addr; rq_io[req_n] = req_is_io; rq_np[req_n] = req_np;
            req_n++;
            if (req_np) cpl_cnt = cpl_delay;
        end
        if (rst_n && bvalid && bready) begin
            b_id[b_n] = bid; b_rs[b_n] = bresp; b_n++;
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic do_write(input logic [31:0] a, input logic [3:0] id, input logic [3:0] c);
        awvalid = 1'b1; wvalid = 1'b1; awaddr = a; wdata = a ^ 32'h5A5A_0000;
        awid = id; awcache = c;
        for (int n = 0; n < 300; n++) begin
            if (awready) break;
            tick();
        end
        tick();
        awvalid = 1'b0; wvalid = 1'b0;
    endtask

    task automatic wait_b(input int target, input int maxc);
        for (int n = 0; n < maxc; n++) begin
            if (b_n >= target) break;
            tick();
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11 reset state
        check(awready == 1'b1, "R11 awready after reset", 32'(awready), 32'd1);
        check(bvalid == 1'b0, "R11 bvalid after reset", 32'(bvalid), 32'd0);
        check(req_valid == 1'b0, "R11 req_valid after reset", 32'(req_valid), 32'd0);

        // table walk: R1 R2 R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            int r0, b0;
            r0 = req_n; b0 = b_n;
            do_write(VEC[i].addr, VEC[i].id, VEC[i].cache);
            wait_b(b0 + 1, 60);
            repeat (4) tick();
            check(b_n == b0 + 1, "R9 one response per write", 32'(b_n - b0), 32'd1);
            check(b_id[b0] == VEC[i].id, "R9 bid matches awid", 32'(b_id[b0]), 32'(VEC[i].id));
            check(b_rs[b0] == VEC[i].exp_resp, "R5 response code", 32'(b_rs[b0]), 32'(VEC[i].exp_resp));
            check((req_n - r0) == int'(VEC[i].exp_req), "R5 request count",
                  32'(req_n - r0), 32'(VEC[i].exp_req));
            if (VEC[i].exp_req && req_n > r0) begin
                check(rq_io[r0] == VEC[i].exp_io, "R1 space select", 32'(rq_io[r0]), 32'(VEC[i].exp_io));
                check(rq_addr[r0] == VEC[i].addr, "R1 request address", rq_addr[r0], VEC[i].addr);
                check(rq_np[r0] == !VEC[i].cache[0], "R4 non-posted flag",
                      32'(rq_np[r0]), 32'(!VEC[i].cache[0]));
            end
        end

        // R2 / R4: response held until a slow completion
        cpl_delay = 12;
        begin
            int b0;
            b0 = b_n;
            do_write(32'h0000_1100, 4'hA, 4'h0);
            repeat (6) tick();
            check(b_n == b0, "R2 I/O response held before completion", 32'(b_n - b0), 32'd0);
            wait_b(b0 + 1, 40);
            check(b_n == b0 + 1 && b_rs[b0] == 2'b00, "R2 I/O response after completion",
                  32'(b_rs[b0]), 32'd0);
            b0 = b_n;
            do_write(32'h9000_0000, 4'hB, 4'h2);
            repeat (6) tick();
            check(b_n == b0, "R4 memory non-bufferable response held", 32'(b_n - b0), 32'd0);
            wait_b(b0 + 1, 40);
            check(b_n == b0 + 1, "R4 response after completion", 32'(b_n - b0), 32'd1);
        end

        // R6 error completion
        cpl_delay = 3; err_mode = 1'b1;
        begin
            int b0;
            b0 = b_n;
            do_write(32'h0000_1200, 4'hC, 4'h0);
            wait_b(b0 + 1, 40);
            check(b_n == b0 + 1 && b_rs[b0] == 2'b10, "R6 error completion gives SLVERR",
                  32'(b_rs[b0]), 32'd2);
        end
        err_mode = 1'b0;

        // R3 early response with downstream stalled
        auto_ready = 1'b0;
        tick();
        begin
            int b0, r0;
            b0 = b_n; r0 = req_n;
            do_write(32'hA000_0000, 4'h3, 4'h1);
            wait_b(b0 + 1, 5);
            check(b_n == b0 + 1 && b_rs[b0] == 2'b00, "R3 posted write answered early",
                  32'(b_n - b0), 32'd1);
            check(req_n == r0, "R3 answered before downstream handshake", 32'(req_n - r0), 32'd0);
            // R8 fill the queue: three more posted writes
            do_write(32'hA000_0004, 4'h4, 4'h1);
            do_write(32'hA000_0008, 4'h5, 4'h1);
            do_write(32'hA000_000C, 4'h6, 4'h1);
            wait_b(b0 + 4, 10);
            tick();
            check(awready == 1'b0, "R8 awready low when queue full", 32'(awready), 32'd0);
            check(b_n == b0 + 4, "R8 four posted writes answered", 32'(b_n - b0), 32'd4);
            check(b_id[b0] == 4'h3 && b_id[b0+3] == 4'h6, "R9 in-order bid",
                  32'(b_id[b0+3]), 32'h6);
            auto_ready = 1'b1;
            repeat (8) tick();
            check(awready == 1'b1, "R8 awready returns after drain", 32'(awready), 32'd1);
            check(req_n == r0 + 4, "R10 all posted writes sent", 32'(req_n - r0), 32'd4);
            for (int k = 0; k < 4; k++)
                check(rq_addr[r0+k] == 32'hA000_0000 + 32'(4*k), "R10 posted order",
                      rq_addr[r0+k], 32'hA000_0000 + 32'(4*k));
        end

        // R10 held write waits behind queued posted writes
        auto_ready = 1'b0;
        tick();
        begin
            int b0, r0;
            b0 = b_n; r0 = req_n;
            do_write(32'hB000_0000, 4'h1, 4'h1);
            do_write(32'hB000_0004, 4'h2, 4'h1);
            do_write(32'h0000_1300, 4'h7, 4'h0);
            repeat (3) tick();
            check(req_n == r0, "R10 nothing sent while stalled", 32'(req_n - r0), 32'd0);
            auto_ready = 1'b1;
            wait_b(b0 + 3, 60);
            check(req_n == r0 + 3, "R10 three requests", 32'(req_n - r0), 32'd3);
            check(rq_addr[r0+2] == 32'h0000_1300 && rq_io[r0+2], "R10 held I/O write last",
                  rq_addr[r0+2], 32'h0000_1300);
            check(b_id[b0+2] == 4'h7, "R9 held response after posted ones", 32'(b_id[b0+2]), 32'h7);
        end

        // R7 back-to-back I/O writes are serialized
        cpl_delay = 8;
        begin
            int b0, r0, c0;
            b0 = b_n; r0 = req_n; c0 = cpl_n;
            do_write(32'h0000_1400, 4'h8, 4'h0);
            repeat (3) tick();
            check(awready == 1'b0, "R7 awready low while I/O pending", 32'(awready), 32'd0);
            do_write(32'h0000_1404, 4'h9, 4'h0);
            check(cpl_n >= c0 + 1, "R7 second accepted only after first completion",
                  32'(cpl_n - c0), 32'd1);
            wait_b(b0 + 2, 60);
            check(req_n == r0 + 2 && b_id[b0+1] == 4'h9, "R7 both I/O writes done in order",
                  32'(req_n - r0), 32'd2);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule